// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Bank

This block is the host-side register bank of a PC-style real-time clock. Software reaches 128 bytes of battery-backed storage through two byte-wide ports. It writes a register number to the index port, then reads or writes that register through the data port. Most bytes are plain storage. Four bytes act as clock control and status registers: the rate/divider control byte at 0x0A, the mode control byte at 0x0B, the interrupt flag byte at 0x0C and the validity byte at 0x0D. These four follow their own write masks and read side effects.

The time-keeping engine and the periodic rate generator live in other blocks. They report events through three one-cycle flag-set inputs and an update-in-progress level. They read back the two control bytes on dedicated outputs. A level interrupt output follows the summary bit of the flag byte. There are two resets. A power-on reset loads the default contents. A bus reset clears only the interrupt-related state.

Top module: `rtc_regbank`

## Requirements
- R1: A write to the index port (portSel = 0) latches wrData[6:0] as the register number, so bit 7 of the written value has no effect on which register is selected.
- R2: A read of the index port returns 0xFF.
- R3: Storage bytes other than 0x0A–0x0D read back the last value written through the data port (portSel = 1).
- R4: A data-port read at 0x0C returns the flags present before the read, then clears the byte to 0x00 at that clock edge and drops irq.
- R5: Data-port writes to 0x0C and 0x0D change nothing. Byte 0x0D reads 0x80 after power-on reset.
- R6: A write to 0x0A sets bits 6..0 from the data. Bit 7 instead shows uipIn as sampled at the previous clock edge, whatever value is written.
- R7: A write to 0x0B stores the data with bit 3 forced to 0. When data bit 7 is 1, bit 4 is also forced to 0.
- R8: A bus reset (rstN low while porN is high) clears bits 6..4 of 0x0B, clears 0x0C and the index latch, and leaves 0x0A, 0x0D and the storage bytes unchanged.
- R9: Power-on reset (porN low) sets 0x0A = 0x26, 0x0B = 0x02, 0x0C = 0x00 and 0x0D = 0x80. All other bytes become 0x00.
- R10: A write to the century byte 0x37 also writes 0x32. A write to 0x32 leaves 0x37 unchanged.
- R11: A setPeriodic pulse sets flag bits 6 and 7, setAlarm sets bits 5 and 7, and setUpdate sets bits 4 and 7. Each sets them at the next edge and ORs them onto the flags already present.
- R12: A flag-set pulse in the same cycle as a clearing read of 0x0C wins over the clear: its bits are present after the edge.
- R13: irq is high exactly when bit 7 of byte 0x0C is 1.
- R14: ctlA and ctlB always show the current contents of bytes 0x0A and 0x0B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Synchronous power-on reset, active low, loads defaults |
| rstN | input | 1 | Synchronous bus reset, active low, partial clear |
| portSel | input | 1 | 0 selects the index port, 1 the data port |
| wrEn | input | 1 | Write strobe for the selected port |
| rdEn | input | 1 | Read strobe for the selected port (side effects on data port) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from the selected port |
| uipIn | input | 1 | Update-in-progress level from the time-keeping engine |
| setPeriodic | input | 1 | Periodic event pulse |
| setAlarm | input | 1 | Alarm event pulse |
| setUpdate | input | 1 | Update-ended event pulse |
| ctlA | output | 8 | Contents of byte 0x0A |
| ctlB | output | 8 | Contents of byte 0x0B |
| irq | output | 1 | Level interrupt, bit 7 of byte 0x0C |

## Verification
A clearing read of the flag byte and an incoming flag-set pulse can land on the same clock edge. The bench provokes this by raising setUpdate in the very cycle it strobes a data-port read at 0x0C. It expects that read to return the old flags, 0x00. It expects the next read to return 0x90, and irq to fall only after that second read. The checks on flag accumulation and the read-ignore rules are built around this collision.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int AddrW = 7;
  localparam int DataW = 8;

  localparam logic [AddrW-1:0] IdxRate   = 7'h0A;
  localparam logic [AddrW-1:0] IdxMode   = 7'h0B;
  localparam logic [AddrW-1:0] IdxFlags  = 7'h0C;
  localparam logic [AddrW-1:0] IdxValid  = 7'h0D;
  localparam logic [AddrW-1:0] IdxCentLo = 7'h32;
  localparam logic [AddrW-1:0] IdxCentHi = 7'h37;

  localparam logic [DataW-1:0] RateDefault  = 8'h26;
  localparam logic [DataW-1:0] ModeDefault  = 8'h02;
  localparam logic [DataW-1:0] ValidDefault = 8'h80;
  localparam logic [DataW-1:0] ModeRstKeep  = 8'h8F;
  localparam logic [DataW-1:0] IndexReadVal = 8'hFF;

  localparam int ModeSquareBit = 3;
  localparam int ModeUieBit    = 4;
  localparam int ModeSetBit    = 7;
  localparam int FlagIrqBit    = 7;
  localparam int FlagPerBit    = 6;
  localparam int FlagAlmBit    = 5;
  localparam int FlagUpdBit    = 4;
  localparam int RateUipBit    = 7;

  typedef struct packed {
    logic             dataWr;
    logic             dataRd;
    logic [AddrW-1:0] addr;
    logic [DataW-1:0] data;
  } busStrobe_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             porN,
  input  logic             rstN,
  input  logic             portSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [DataW-1:0] wrData,
  output busStrobe_t       strobe
);
  logic [AddrW-1:0] idxQ;
  logic             idxLoad;

  assign idxLoad = wrEn && !portSel;

  always_ff @(posedge clk) begin
    if (!porN || !rstN) idxQ <= '0;
    else if (idxLoad)   idxQ <= wrData[AddrW-1:0];
  end

  always_comb begin
    strobe.dataWr = wrEn && portSel;
    strobe.dataRd = rdEn && portSel;
    strobe.addr   = idxQ;
    strobe.data   = wrData;
  end

  // R1: the latch takes only the low address bits of the written byte
  a_r1_index_load: assert property (@(posedge clk) disable iff (!porN || !rstN)
    idxLoad |=> (strobe.addr == $past(wrData[AddrW-1:0])));

  // R8: a bus reset leaves the index at register zero
  a_r8_index_clear: assert property (@(posedge clk) disable iff (!porN)
    !rstN |=> (strobe.addr == '0));
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int Depth = 1 << AddrW
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             rstN,
  input  busStrobe_t       strobe,
  input  logic             uipIn,
  input  logic             setPeriodic,
  input  logic             setAlarm,
  input  logic             setUpdate,
  output logic [DataW-1:0] rdByte,
  output logic [DataW-1:0] ctlA,
  output logic [DataW-1:0] ctlB,
  output logic             irq
);
  logic [DataW-1:0] mem [Depth];
  logic [DataW-1:0] modeNext;
  logic [DataW-1:0] flagsNext;
  logic [DataW-1:0] setBits;
  logic             setAny;
  logic             flagRead;

  assign setAny   = setPeriodic || setAlarm || setUpdate;
  assign flagRead = strobe.dataRd && (strobe.addr == IdxFlags);

  always_comb begin
    setBits             = '0;
    setBits[FlagIrqBit] = setAny;
    setBits[FlagPerBit] = setPeriodic;
    setBits[FlagAlmBit] = setAlarm;
    setBits[FlagUpdBit] = setUpdate;
    flagsNext = (flagRead ? '0 : mem[IdxFlags]) | setBits;
  end

  always_comb begin
    modeNext                = strobe.data;
    modeNext[ModeSquareBit] = 1'b0;
    if (strobe.data[ModeSetBit]) modeNext[ModeUieBit] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!porN) begin
      for (int i = 0; i < Depth; i++) mem[i] <= '0;
      mem[IdxRate]  <= RateDefault;
      mem[IdxMode]  <= ModeDefault;
      mem[IdxValid] <= ValidDefault;
    end else if (!rstN) begin
      mem[IdxMode]  <= mem[IdxMode] & ModeRstKeep;
      mem[IdxFlags] <= '0;
      mem[IdxRate][RateUipBit] <= uipIn;
    end else begin
      if (strobe.dataWr) begin
        case (strobe.addr)
          IdxRate:  mem[IdxRate][RateUipBit-1:0] <= strobe.data[RateUipBit-1:0];
          IdxMode:  mem[IdxMode] <= modeNext;
          IdxFlags, IdxValid: ;
          IdxCentHi: begin
            mem[IdxCentHi] <= strobe.data;
            mem[IdxCentLo] <= strobe.data;
          end
          default:  mem[strobe.addr] <= strobe.data;
        endcase
      end
      mem[IdxFlags] <= flagsNext;
      mem[IdxRate][RateUipBit] <= uipIn;
    end
  end

  assign rdByte = mem[strobe.addr];
  assign ctlA   = mem[IdxRate];
  assign ctlB   = mem[IdxMode];
  assign irq    = mem[IdxFlags][FlagIrqBit];

  // R4: a clearing read with no new event empties the flag byte
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (flagRead && !setAny) |=> (mem[IdxFlags] == '0) && !irq);

  // R12: a set pulse survives a simultaneous clearing read
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!porN || !rstN)
    setAny |=> irq);

  // R13: the interrupt only rises after an event pulse
  a_r13_irq_source: assert property (@(posedge clk) disable iff (!porN || !rstN)
    $rose(irq) |-> $past(setAny));

  // R5: writes to the flag byte do not disturb it
  a_r5_flags_ro: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (strobe.dataWr && strobe.addr == IdxFlags && !setAny && !strobe.dataRd)
      |=> (mem[IdxFlags] == $past(mem[IdxFlags])));

  // R6: the busy bit tracks the engine level, not the bus
  a_r6_uip_follow: assert property (@(posedge clk) disable iff (!porN)
    1'b1 |=> (ctlA[RateUipBit] == $past(uipIn)));

  // R7: square-wave bit never set, and SET excludes update-ended enable
  a_r7_mode_mask: assert property (@(posedge clk) disable iff (!porN || !rstN)
    !ctlB[ModeSquareBit] && !(ctlB[ModeSetBit] && ctlB[ModeUieBit]));
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             porN,
  input  logic             rstN,
  input  logic             portSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] rdData,
  input  logic             uipIn,
  input  logic             setPeriodic,
  input  logic             setAlarm,
  input  logic             setUpdate,
  output logic [DataW-1:0] ctlA,
  output logic [DataW-1:0] ctlB,
  output logic             irq
);
  busStrobe_t       strobe;
  logic [DataW-1:0] rdByte;

  rtc_ctrl u_ctrl (
    .clk     (clk),
    .porN    (porN),
    .rstN    (rstN),
    .portSel (portSel),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .wrData  (wrData),
    .strobe  (strobe)
  );

  rtc_datapath u_dp (
    .clk         (clk),
    .porN        (porN),
    .rstN        (rstN),
    .strobe      (strobe),
    .uipIn       (uipIn),
    .setPeriodic (setPeriodic),
    .setAlarm    (setAlarm),
    .setUpdate   (setUpdate),
    .rdByte      (rdByte),
    .ctlA        (ctlA),
    .ctlB        (ctlB),
    .irq         (irq)
  );

  assign rdData = portSel ? rdByte : IndexReadVal;
endmodule

// File: tb/sim_rtc_regbank.sv
`timescale 1ns/1ps
module sim_rtc_regbank;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       porN, rstN, portSel, wrEn, rdEn, uipIn;
  logic       setPeriodic, setAlarm, setUpdate, irq;
  logic [7:0] wrData, rdData, ctlA, ctlB;

  rtc_regbank u0 (
    .clk(clk), .porN(porN), .rstN(rstN), .portSel(portSel), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .uipIn(uipIn),
    .setPeriodic(setPeriodic), .setAlarm(setAlarm), .setUpdate(setUpdate),
    .ctlA(ctlA), .ctlB(ctlB), .irq(irq)
  );

  typedef struct {
    int         kind;   // 0 rdData, 1 irq, 2 ctlA, 3 ctlB
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  event  sampleEv;
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  task automatic drain();
    while (q.size() > 0) begin
      item_t      it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = rdData;
        1:       act = {7'b0, irq};
        2:       act = ctlA;
        default: act = ctlB;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  endtask

  initial forever begin
    @(sampleEv);
    drain();
  end

  task automatic expectVal(int kind, logic [7:0] v, string tag);
    item_t it;
    it.kind = kind; it.exp = v; it.tag = tag;
    q.push_back(it);
    -> sampleEv;
    #0;
  endtask

  task automatic busDrive(bit sel, bit we, bit re, logic [7:0] d);
    @(negedge clk);
    portSel = sel; wrEn = we; rdEn = re; wrData = d;
  endtask

  task automatic busEnd();
    @(posedge clk);
    #1 wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic wrIdx(logic [7:0] v);
    busDrive(1'b0, 1'b1, 1'b0, v); busEnd();
  endtask

  task automatic wrReg(logic [7:0] a, logic [7:0] v);
    wrIdx(a); busDrive(1'b1, 1'b1, 1'b0, v); busEnd();
  endtask

  task automatic rdCur(logic [7:0] e, string tag);
    busDrive(1'b1, 1'b0, 1'b1, 8'h00);
    #1 expectVal(0, e, tag);
    busEnd();
  endtask

  task automatic rdReg(logic [7:0] a, logic [7:0] e, string tag);
    wrIdx(a); rdCur(e, tag);
  endtask

  task automatic checkOut(int kind, logic [7:0] e, string tag);
    @(negedge clk);
    #1 expectVal(kind, e, tag);
  endtask

  task automatic pulse(bit p, bit a, bit u);
    @(negedge clk);
    setPeriodic = p; setAlarm = a; setUpdate = u;
    @(posedge clk);
    #1 setPeriodic = 1'b0; setAlarm = 1'b0; setUpdate = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    porN = 0; rstN = 0; portSel = 0; wrEn = 0; rdEn = 0; wrData = 0;
    uipIn = 0; setPeriodic = 0; setAlarm = 0; setUpdate = 0;
    repeat (3) @(negedge clk);
    porN = 1; rstN = 1;

    // R9 power-on contents, R5 validity byte, R13/R14 outputs
    checkOut(1, 8'h00, "R13 irq low after power-on");
    checkOut(2, 8'h26, "R14 ctlA default");
    rdReg(8'h0A, 8'h26, "R9 rate byte default");
    rdReg(8'h0B, 8'h02, "R9 mode byte default");
    rdReg(8'h0C, 8'h00, "R9 flags default");
    rdReg(8'h0D, 8'h80, "R5 validity byte default");
    rdReg(8'h20, 8'h00, "R9 storage cleared");

    // R2 index port read
    busDrive(1'b0, 1'b0, 1'b1, 8'h00);
    #1 expectVal(0, 8'hFF, "R2 index read");
    busEnd();

    // R1 / R3 storage access with bit 7 of index ignored
    wrReg(8'h8E, 8'h5A);
    rdReg(8'h0E, 8'h5A, "R1 high index bit dropped");
    wrReg(8'h7F, 8'hC3);
    rdReg(8'hFF, 8'hC3, "R3 top byte storage");

    // R6 rate byte
    wrReg(8'h0A, 8'hFF);
    rdReg(8'h0A, 8'h7F, "R6 busy bit not writable");
    @(negedge clk) uipIn = 1'b1;
    wrReg(8'h0A, 8'h00);
    rdReg(8'h0A, 8'h80, "R6 busy bit follows level");
    checkOut(2, 8'h80, "R14 ctlA tracks");
    @(negedge clk) uipIn = 1'b0;
    @(negedge clk);

    // R7 mode byte masks
    wrReg(8'h0B, 8'hFF);
    rdReg(8'h0B, 8'hE7, "R7 set clears bits 3 and 4");
    wrReg(8'h0B, 8'h7F);
    rdReg(8'h0B, 8'h77, "R7 bit 3 forced low");
    checkOut(3, 8'h77, "R14 ctlB tracks");

    // R5 read-only bytes
    wrReg(8'h0C, 8'hFF);
    rdReg(8'h0C, 8'h00, "R5 flags write ignored");
    checkOut(1, 8'h00, "R5 irq unchanged by write");
    wrReg(8'h0D, 8'h00);
    rdReg(8'h0D, 8'h80, "R5 validity write ignored");

    // R10 century mirror
    wrReg(8'h37, 8'h20);
    rdReg(8'h32, 8'h20, "R10 mirror copy");
    rdReg(8'h37, 8'h20, "R10 primary byte");
    wrReg(8'h32, 8'h19);
    rdReg(8'h37, 8'h20, "R10 low byte write one-way");

    // R11 / R4 / R13 flag handling
    pulse(1'b1, 1'b0, 1'b0);
    checkOut(1, 8'h01, "R13 irq after periodic event");
    rdReg(8'h0C, 8'hC0, "R11 periodic flags");
    rdCur(8'h00, "R4 cleared by read");
    checkOut(1, 8'h00, "R4 irq dropped");
    pulse(1'b0, 1'b1, 1'b0);
    pulse(1'b0, 1'b0, 1'b1);
    rdCur(8'hB0, "R11 alarm and update accumulate");

    // R12 set and clear in the same cycle
    busDrive(1'b1, 1'b0, 1'b1, 8'h00);
    setUpdate = 1'b1;
    #1 expectVal(0, 8'h00, "R12 read returns old flags");
    busEnd();
    setUpdate = 1'b0;
    checkOut(1, 8'h01, "R12 irq kept");
    rdCur(8'h90, "R12 new flag survived");
    checkOut(1, 8'h00, "R4 irq low after second read");

    // R8 bus reset
    wrReg(8'h00, 8'h11);
    wrReg(8'h0A, 8'h2A);
    pulse(1'b0, 1'b1, 1'b0);
    wrIdx(8'h0E);
    @(negedge clk) rstN = 1'b0;
    @(posedge clk);
    #1 rstN = 1'b1;
    checkOut(1, 8'h00, "R8 irq cleared");
    rdCur(8'h11, "R8 index back to zero");
    rdReg(8'h0B, 8'h07, "R8 enables cleared");
    rdReg(8'h0A, 8'h2A, "R8 rate byte kept");
    rdReg(8'h0C, 8'h00, "R8 flags cleared");
    rdReg(8'h0D, 8'h80, "R8 validity kept");
    rdReg(8'h0E, 8'h5A, "R8 storage kept");

    #1 drain();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule